// File: doc/BRIEF.md
# I2C Target Message Transfer Engine

This block sits behind an I2C target byte interface and exchanges framed messages with an embedded controller. For every byte event it is given four status flags (interrupt, address phase, read direction, end of transaction) and the byte that was received. It returns the byte to put on the bus when the controller reads. A five-state sequencer works out the direction of each transfer from its first command byte. When the controller writes, the bytes are gathered into a receive store and the count is checked against the size that the header byte encodes. When the controller reads, the queued outgoing frame is sent. If nothing is queued, a fixed three-byte no-op frame is sent instead.

Software side: outgoing payloads are loaded one byte at a time through a ready/valid port. A received message can be read back by index. An active-low request line tells the controller that there is something to collect. The line is released once the controller has started a read.

Top module: `i2c_tgt_msg_engine`

## Requirements
- R1: After reset `req_n` is 1, `ld_ready` is 1, and `tx_we`, `rx_done`, `rx_resp` and `addr_bad` are 0.
- R2: An event whose flags are exactly interrupt plus address phase starts a transfer from any state. The state becomes command-wait. One cycle later `addr_bad` pulses if `evt_byte` differs from `own_addr`.
- R3: In command-wait, an interrupt-only event stores `evt_byte` as receive byte 0. Any other flag combination drops the sequencer to idle, so a following end event produces no `rx_done`.
- R4: The expected receive length comes from byte 0 (h) and byte 1 (n). If h[7]=0, the length is n+2. If h[7]=1, h[6:5] selects the length: 0 gives 2, 1 gives 3, 2 gives n+2, and 3 gives 0.
- R5: In write-data state, an end event with the read flag clear pulses `rx_done` one cycle later. `rx_len` then holds the stored byte count, and `rx_good` is 1 only if the count equals the R4 length. The stored bytes can be read through `rd_idx`/`rd_data`.
- R6: `rx_resp` pulses together with `rx_done` only when `rx_good` is 1 and byte 0 bit 7 is clear.
- R7: Write-data bytes beyond `MSG_MAX` are dropped, so `rx_len` never exceeds `MSG_MAX`.
- R8: A read-start event (interrupt, address and read flags, end clear) seen after the command byte is honoured only if the command is 0x01. Otherwise the sequencer goes idle and the byte sent is 0xFF.
- R9: An outgoing frame is sent as the payload length first, then the payload bytes in load order. The frame is payload length + 1 bytes long.
- R10: If no frame is queued when a read is honoured, the bytes 0x02, 0x07, 0x02 are sent.
- R11: An end event during sending, after fewer bytes than the frame length, rewinds the frame to byte 0 and drives `req_n` low. An end event after the whole frame has gone out frees the queued frame, so `ld_ready` returns to 1.
- R12: `req_n` falls one cycle after the last payload byte is loaded. It rises one cycle after any read-start event.
- R13: `tx_we` pulses one cycle after an event only if the read flag is set and the end flag is clear. The byte is 0xFF whenever there is nothing left to send.
- R14: Events with the interrupt flag clear change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_addr | input | 8 | Expected address byte |
| evt_valid | input | 1 | One byte event this cycle |
| evt_irq | input | 1 | Interrupt flag |
| evt_adr | input | 1 | Address-phase flag |
| evt_rd | input | 1 | Read-direction flag |
| evt_fin | input | 1 | End-of-transaction flag |
| evt_byte | input | 8 | Byte received from the bus |
| tx_we | output | 1 | Transmit byte write strobe |
| tx_byte | output | 8 | Byte to transmit |
| req_n | output | 1 | Active-low poll request to the controller |
| ld_valid | input | 1 | Payload byte valid |
| ld_ready | output | 1 | Loader can accept a byte |
| ld_byte | input | 8 | Payload byte |
| ld_last | input | 1 | Last payload byte of the frame |
| rx_done | output | 1 | Receive completed (pulse) |
| rx_good | output | 1 | Receive length matched |
| rx_resp | output | 1 | Good response received (pulse) |
| rx_len | output | CNT_W | Bytes stored in the finished receive |
| rd_idx | input | IDX_W | Receive store read index |
| rd_data | output | 8 | Receive store read data |
| addr_bad | output | 1 | Address mismatch on a start (pulse) |

## Verification
Every result of an event is registered, so `tx_we`/`tx_byte`, `rx_done`/`rx_good`/`rx_resp`/`rx_len`, `addr_bad` and `req_n` all change on the first clock edge after the event is presented. The bench drives each event for a single cycle and compares all of these outputs at the falling edge that follows that rising edge. A load commit moves `req_n` on the same one-cycle delay. Store read-back through `rd_idx` is combinational and is sampled a short delay after the index is set.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_CMD  = 3'd1,
    S_HDR  = 3'd2,
    S_SEND = 3'd3,
    S_DATA = 3'd4
  } seq_t;

  localparam logic [7:0] READ_CMD  = 8'h01;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  // fixed filler frame sent when nothing is queued
  function automatic logic [7:0] noop_byte(input logic [7:0] idx);
    case (idx)
      8'd0:    return 8'h02;
      8'd1:    return 8'h07;
      8'd2:    return 8'h02;
      default: return IDLE_BYTE;
    endcase
  endfunction

  // expected frame length from the two header bytes
  function automatic logic [8:0] exp_size(input logic [7:0] h, input logic [7:0] n);
    if (!h[7] || h[6:5] == 2'd2) return {1'b0, n} + 9'd2;
    case (h[6:5])
      2'd0:    return 9'd2;
      2'd1:    return 9'd3;
      default: return 9'd0;
    endcase
  endfunction
endpackage

// File: rtl/i2ct_rx_buf.sv
module i2ct_rx_buf #(
  parameter int MSG_MAX = 32,
  localparam int CNT_W = $clog2(MSG_MAX + 1),
  localparam int IDX_W = $clog2(MSG_MAX),
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_first,
  input  logic             wr_app,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic [7:0]       hdr0,
  output logic [7:0]       hdr1
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_first) begin
      mem[0] <= wr_byte;
      cnt    <= CNT_W'(1);
    end else if (wr_app && !full) begin
      mem[cnt[IDX_W-1:0]] <= wr_byte;
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign full    = (cnt == CNT_W'(MSG_MAX));
  assign hdr0    = mem[0];
  assign hdr1    = mem[1];
  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/i2ct_tx_buf.sv
module i2ct_tx_buf #(
  parameter int MAX_PAY = 31,
  localparam int PL_W  = $clog2(MAX_PAY + 1),
  localparam int FRM_W = $clog2(MAX_PAY + 2),
  localparam int DEPTH = 1 << FRM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [7:0]       ld_byte,
  input  logic             ld_last,
  output logic             ld_ready,
  output logic             ld_commit,
  input  logic             release_frm,
  output logic             pending,
  output logic [FRM_W-1:0] frm_size,
  input  logic [FRM_W-1:0] rd_pos,
  output logic [7:0]       rd_byte
);
  logic [7:0]      pay [DEPTH];
  logic [PL_W-1:0] wcnt, plen;
  logic            take, store;
  logic [FRM_W-1:0] k;

  assign ld_ready  = !pending;
  assign take      = ld_valid && ld_ready;
  assign store     = take && (wcnt < PL_W'(MAX_PAY));
  assign ld_commit = take && ld_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt    <= '0;
      plen    <= '0;
      pending <= 1'b0;
      for (int i = 0; i < DEPTH; i++) pay[i] <= 8'h00;
    end else begin
      if (store) pay[FRM_W'(wcnt)] <= ld_byte;
      if (ld_commit) begin
        plen    <= wcnt + (store ? PL_W'(1) : PL_W'(0));
        wcnt    <= '0;
        pending <= 1'b1;
      end else begin
        if (store) wcnt <= wcnt + PL_W'(1);
        if (release_frm) pending <= 1'b0;
      end
    end
  end

  assign frm_size = FRM_W'(plen) + FRM_W'(1);
  assign k        = rd_pos - FRM_W'(1);

  always_comb begin
    if (rd_pos == '0)                rd_byte = 8'(plen);
    else if (rd_pos <= FRM_W'(plen)) rd_byte = pay[k];
    else                             rd_byte = 8'hFF;
  end
endmodule

// File: rtl/i2ct_seq.sv
module i2ct_seq
  import i2ct_pkg::*;
#(
  parameter int MSG_MAX = 32,
  parameter int MAX_PAY = 31,
  localparam int CNT_W = $clog2(MSG_MAX + 1),
  localparam int FRM_W = $clog2(MAX_PAY + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       own_addr,
  input  logic             evt_valid,
  input  logic             evt_irq,
  input  logic             evt_adr,
  input  logic             evt_rd,
  input  logic             evt_fin,
  input  logic [7:0]       evt_byte,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             rx_full,
  input  logic [7:0]       rx_hdr0,
  input  logic [7:0]       rx_hdr1,
  output logic             wr_first,
  output logic             wr_app,
  input  logic             tx_pending,
  input  logic             ld_commit,
  input  logic [FRM_W-1:0] frm_size,
  input  logic [7:0]       frm_byte,
  output logic [FRM_W-1:0] frm_pos,
  output logic             release_frm,
  output logic             tx_we,
  output logic [7:0]       tx_byte,
  output logic             req_n,
  output logic             rx_done,
  output logic             rx_good,
  output logic             rx_resp,
  output logic [CNT_W-1:0] rx_len,
  output logic             addr_bad
);
  seq_t             st_q, st_n;
  logic [FRM_W-1:0] pos_q, pos_n, cur_size;
  logic             noop_q, noop_n, req_d;
  logic             act, irq_only, rd_start, xfer_start;
  logic [7:0]       send_d, cur_byte;
  logic             we_d, done_d, good_d, resp_d, bad_d;

  assign act        = evt_valid && evt_irq;
  assign irq_only   = !evt_adr && !evt_rd && !evt_fin;
  assign rd_start   = evt_adr && evt_rd && !evt_fin;
  assign xfer_start = evt_adr && !evt_rd && !evt_fin;

  assign frm_pos  = (st_q == S_SEND) ? pos_q : '0;
  assign cur_size = noop_q ? FRM_W'(3) : frm_size;
  assign cur_byte = noop_q ? noop_byte(8'(pos_q)) : frm_byte;

  always_comb begin
    st_n        = st_q;
    pos_n       = pos_q;
    noop_n      = noop_q;
    req_d       = req_n;
    send_d      = IDLE_BYTE;
    we_d        = 1'b0;
    done_d      = 1'b0;
    good_d      = 1'b0;
    resp_d      = 1'b0;
    bad_d       = 1'b0;
    wr_first    = 1'b0;
    wr_app      = 1'b0;
    release_frm = 1'b0;
    if (ld_commit) req_d = 1'b0;
    if (act) begin
      case (st_q)
        S_CMD: begin
          if (irq_only) begin
            wr_first = 1'b1;
            st_n     = S_HDR;
          end else st_n = S_IDLE;
        end
        S_HDR: begin
          if (rd_start) begin
            if (rx_hdr0 == READ_CMD) begin
              st_n   = S_SEND;
              noop_n = !tx_pending;
              send_d = tx_pending ? frm_byte : noop_byte(8'd0);
              pos_n  = FRM_W'(1);
            end else st_n = S_IDLE;
          end else if (irq_only) begin
            wr_app = 1'b1;
            st_n   = S_DATA;
          end else st_n = S_IDLE;
        end
        S_SEND: begin
          if (evt_fin) begin
            if (pos_q != cur_size) begin
              pos_n = '0;
              req_d = 1'b0;
            end else begin
              st_n        = S_IDLE;
              release_frm = !noop_q;
            end
          end else if (!evt_rd || evt_adr) begin
            st_n = S_IDLE;
          end else if (pos_q < cur_size) begin
            send_d = cur_byte;
            pos_n  = pos_q + FRM_W'(1);
          end else st_n = S_IDLE;
        end
        S_DATA: begin
          if (evt_fin && !evt_rd) begin
            done_d = 1'b1;
            good_d = (16'(rx_cnt) == 16'(exp_size(rx_hdr0, rx_hdr1)));
            resp_d = good_d && !rx_hdr0[7];
            st_n   = S_IDLE;
          end else if (evt_rd || evt_adr) begin
            st_n = S_IDLE;
          end else if (!rx_full) begin
            wr_app = 1'b1;
          end
        end
        default: st_n = S_IDLE;
      endcase
      if (xfer_start) begin
        st_n  = S_CMD;
        bad_d = (evt_byte != own_addr);
      end
      if (evt_rd && !evt_fin) we_d = 1'b1;
      if (rd_start) req_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pos_q    <= '0;
      noop_q   <= 1'b0;
      req_n    <= 1'b1;
      tx_we    <= 1'b0;
      tx_byte  <= IDLE_BYTE;
      rx_done  <= 1'b0;
      rx_good  <= 1'b0;
      rx_resp  <= 1'b0;
      rx_len   <= '0;
      addr_bad <= 1'b0;
    end else begin
      st_q     <= st_n;
      pos_q    <= pos_n;
      noop_q   <= noop_n;
      req_n    <= req_d;
      tx_we    <= we_d;
      tx_byte  <= we_d ? send_d : IDLE_BYTE;
      rx_done  <= done_d;
      rx_good  <= good_d;
      rx_resp  <= resp_d;
      addr_bad <= bad_d;
      if (done_d) rx_len <= rx_cnt;
    end
  end
endmodule

// File: rtl/i2c_tgt_msg_engine.sv
module i2c_tgt_msg_engine #(
  parameter int MSG_MAX = 32,
  parameter int MAX_PAY = 31,
  localparam int CNT_W = $clog2(MSG_MAX + 1),
  localparam int IDX_W = $clog2(MSG_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       own_addr,
  input  logic             evt_valid,
  input  logic             evt_irq,
  input  logic             evt_adr,
  input  logic             evt_rd,
  input  logic             evt_fin,
  input  logic [7:0]       evt_byte,
  output logic             tx_we,
  output logic [7:0]       tx_byte,
  output logic             req_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [7:0]       ld_byte,
  input  logic             ld_last,
  output logic             rx_done,
  output logic             rx_good,
  output logic             rx_resp,
  output logic [CNT_W-1:0] rx_len,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             addr_bad
);
  localparam int FRM_W = $clog2(MAX_PAY + 2);

  logic [CNT_W-1:0] rx_cnt;
  logic             rx_full, wr_first, wr_app;
  logic [7:0]       rx_hdr0, rx_hdr1, frm_byte;
  logic             tx_pending, ld_commit, release_frm;
  logic [FRM_W-1:0] frm_size, frm_pos;

  i2ct_rx_buf #(.MSG_MAX(MSG_MAX)) u_rx (
    .clk(clk), .rst_n(rst_n), .wr_first(wr_first), .wr_app(wr_app),
    .wr_byte(evt_byte), .rd_idx(rd_idx), .rd_data(rd_data), .cnt(rx_cnt),
    .full(rx_full), .hdr0(rx_hdr0), .hdr1(rx_hdr1)
  );

  i2ct_tx_buf #(.MAX_PAY(MAX_PAY)) u_tx (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_byte(ld_byte),
    .ld_last(ld_last), .ld_ready(ld_ready), .ld_commit(ld_commit),
    .release_frm(release_frm), .pending(tx_pending), .frm_size(frm_size),
    .rd_pos(frm_pos), .rd_byte(frm_byte)
  );

  i2ct_seq #(.MSG_MAX(MSG_MAX), .MAX_PAY(MAX_PAY)) u_seq (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .evt_valid(evt_valid),
    .evt_irq(evt_irq), .evt_adr(evt_adr), .evt_rd(evt_rd), .evt_fin(evt_fin),
    .evt_byte(evt_byte), .rx_cnt(rx_cnt), .rx_full(rx_full),
    .rx_hdr0(rx_hdr0), .rx_hdr1(rx_hdr1), .wr_first(wr_first),
    .wr_app(wr_app), .tx_pending(tx_pending), .ld_commit(ld_commit),
    .frm_size(frm_size), .frm_byte(frm_byte), .frm_pos(frm_pos),
    .release_frm(release_frm), .tx_we(tx_we), .tx_byte(tx_byte),
    .req_n(req_n), .rx_done(rx_done), .rx_good(rx_good), .rx_resp(rx_resp),
    .rx_len(rx_len), .addr_bad(addr_bad)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk #(
  parameter int MSG_MAX = 32,
  localparam int CNT_W = $clog2(MSG_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             evt_irq,
  input logic             evt_adr,
  input logic             evt_rd,
  input logic             evt_fin,
  input logic             ld_valid,
  input logic             ld_ready,
  input logic             ld_last,
  input logic             tx_we,
  input logic [7:0]       tx_byte,
  input logic             req_n,
  input logic             rx_done,
  input logic             rx_good,
  input logic             rx_resp,
  input logic [CNT_W-1:0] rx_len
);
  AST_TX_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_we |-> $past(evt_valid && evt_irq && evt_rd && !evt_fin)); // R13
  AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_we |-> tx_byte == 8'hFF); // R13
  AST_REQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> $past(evt_valid && evt_irq && evt_adr && evt_rd && !evt_fin)); // R12
  AST_REQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past((ld_valid && ld_ready && ld_last) || (evt_valid && evt_irq && evt_fin))); // R11
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(evt_valid && evt_irq && evt_fin && !evt_rd)); // R5
  AST_RESP_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_resp |-> (rx_done && rx_good)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rx_len <= CNT_W'(MSG_MAX)); // R7
endmodule

bind i2c_tgt_msg_engine i2ct_chk #(.MSG_MAX(MSG_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_irq(evt_irq),
  .evt_adr(evt_adr), .evt_rd(evt_rd), .evt_fin(evt_fin), .ld_valid(ld_valid),
  .ld_ready(ld_ready), .ld_last(ld_last), .tx_we(tx_we), .tx_byte(tx_byte),
  .req_n(req_n), .rx_done(rx_done), .rx_good(rx_good), .rx_resp(rx_resp),
  .rx_len(rx_len)
);

// File: tb/sim_i2c_tgt_msg_engine.sv
`timescale 1ns/1ps
module sim_i2c_tgt_msg_engine;
  localparam int MSG_MAX = 32;
  localparam logic [7:0] OWN = 8'h8A;

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_irq = 0, evt_adr = 0, evt_rd = 0, evt_fin = 0;
  logic [7:0] evt_byte = 0;
  logic ld_valid = 0, ld_last = 0;
  logic [7:0] ld_byte = 0;
  logic [4:0] rd_idx = 0;
  logic tx_we, req_n, ld_ready, rx_done, rx_good, rx_resp, addr_bad;
  logic [7:0] tx_byte, rd_data;
  logic [5:0] rx_len;

  always #10 clk = ~clk;

  i2c_tgt_msg_engine u0 (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .evt_valid(evt_valid),
    .evt_irq(evt_irq), .evt_adr(evt_adr), .evt_rd(evt_rd), .evt_fin(evt_fin),
    .evt_byte(evt_byte), .tx_we(tx_we), .tx_byte(tx_byte), .req_n(req_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_byte(ld_byte),
    .ld_last(ld_last), .rx_done(rx_done), .rx_good(rx_good),
    .rx_resp(rx_resp), .rx_len(rx_len), .rd_idx(rd_idx), .rd_data(rd_data),
    .addr_bad(addr_bad)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int ms = 0;
  int mrx[$];
  int mfr[$];
  bit mpend = 0, mnoop = 0, mreq = 1;
  int mpos = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int want_len(input int h, input int n);
    if (h < 128) return n + 2;
    case ((h >> 5) & 3)
      0: return 2;
      1: return 3;
      2: return n + 2;
      default: return 0;
    endcase
  endfunction

  function automatic int fsize();
    return mnoop ? 3 : mfr.size();
  endfunction

  function automatic int fbyte(input int k);
    int nz[3] = '{2, 7, 2};
    if (mnoop) return nz[k];
    return mfr[k];
  endfunction

  // one bus event; predicts and checks the registered outputs one edge later
  task automatic ev(input bit i, input bit a, input bit r, input bit f, input int b, input string req);
    bit e_we = 0, e_done = 0, e_good = 0, e_resp = 0, e_bad = 0;
    int e_tb = 255, e_len = 0;
    bit io = i && !a && !r && !f;
    bit rs = i && a && r && !f;
    bit st = i && a && !r && !f;
    if (i) begin
      if (ms == 1) begin
        if (io) begin mrx.delete(); mrx.push_back(b); ms = 2; end else ms = 0;
      end else if (ms == 2) begin
        if (rs) begin
          if (mrx[0] == 1) begin ms = 3; mnoop = !mpend; e_tb = fbyte(0); mpos = 1; end
          else ms = 0;
        end else if (io) begin mrx.push_back(b); ms = 4; end
        else ms = 0;
      end else if (ms == 3) begin
        if (f) begin
          if (mpos != fsize()) begin mpos = 0; mreq = 0; end
          else begin ms = 0; if (!mnoop) mpend = 0; end
        end else if (!r || a) ms = 0;
        else if (mpos < fsize()) begin e_tb = fbyte(mpos); mpos++; end
        else ms = 0;
      end else if (ms == 4) begin
        if (f && !r) begin
          e_done = 1; e_len = mrx.size();
          e_good = (e_len == want_len(mrx[0], mrx[1]));
          e_resp = e_good && mrx[0] < 128; ms = 0;
        end else if (r || a) ms = 0;
        else if (mrx.size() < MSG_MAX) mrx.push_back(b);
      end
      if (st) begin ms = 1; e_bad = (b[7:0] != OWN); end
      if (r && !f) e_we = 1;
      if (rs) mreq = 1;
    end
    @(negedge clk);
    evt_valid = 1; evt_irq = i; evt_adr = a; evt_rd = r; evt_fin = f; evt_byte = b[7:0];
    @(negedge clk);
    evt_valid = 0; evt_irq = 0; evt_adr = 0; evt_rd = 0; evt_fin = 0;
    chk(tx_we == e_we, req, "tx_we", tx_we, e_we);
    if (e_we) chk(tx_byte == e_tb[7:0], req, "tx_byte", tx_byte, e_tb);
    chk(rx_done == e_done, req, "rx_done", rx_done, e_done);
    if (e_done) begin
      chk(rx_good == e_good, req, "rx_good", rx_good, e_good);
      chk(rx_len == e_len, req, "rx_len", rx_len, e_len);
    end
    chk(rx_resp == e_resp, req, "rx_resp", rx_resp, e_resp);
    chk(addr_bad == e_bad, req, "addr_bad", addr_bad, e_bad);
    chk(req_n == mreq, req, "req_n", req_n, mreq);
    chk(ld_ready == !mpend, req, "ld_ready", ld_ready, !mpend);
  endtask

  task automatic load(input int q[$]);
    foreach (q[k]) begin
      @(negedge clk);
      ld_valid = 1; ld_byte = q[k][7:0]; ld_last = (k == q.size() - 1);
    end
    @(negedge clk);
    ld_valid = 0; ld_last = 0;
    mpend = 1; mreq = 0;
    mfr.delete(); mfr.push_back(q.size());
    foreach (q[k]) mfr.push_back(q[k]);
    chk(req_n == 0, "R12", "req_n after load", req_n, 0);
    chk(ld_ready == 0, "R11", "ld_ready while queued", ld_ready, 0);
  endtask

  task automatic readback(input string req);
    foreach (mrx[k]) begin
      rd_idx = k[4:0];
      #1;
      chk(rd_data == mrx[k][7:0], req, "stored byte", rd_data, mrx[k]);
    end
  endtask

  // controller write of a whole message
  task automatic wr_msg(input int q[$], input string req);
    ev(1, 1, 0, 0, OWN, req);
    foreach (q[k]) ev(1, 0, 0, 0, q[k], req);
    ev(1, 0, 0, 1, 0, req);
  endtask

  // controller read: command 0x01, read start, n more reads, end
  task automatic rd_msg(input int n, input string req);
    ev(1, 1, 0, 0, OWN, req);
    ev(1, 0, 0, 0, 1, req);
    ev(1, 1, 1, 0, OWN, req);
    for (int k = 0; k < n; k++) ev(1, 0, 1, 0, 0, req);
    ev(1, 0, 1, 1, 0, req);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int big[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_n == 1, "R1", "req_n", req_n, 1);
    chk(ld_ready == 1, "R1", "ld_ready", ld_ready, 1);
    chk(tx_we == 0 && rx_done == 0 && addr_bad == 0 && rx_resp == 0, "R1", "pulses", 0, 0);

    wr_msg('{8'h80, 8'h3C}, "R4");                  // event, fixed 2 bytes
    readback("R5");
    wr_msg('{8'h01, 8'h02, 8'hAA, 8'hBB}, "R6");     // response, n+2
    readback("R5");
    wr_msg('{8'h01, 8'h03, 8'hAA}, "R5");            // short response
    wr_msg('{8'hA0, 8'h11, 8'h22}, "R4");            // event, fixed 3 bytes
    wr_msg('{8'hC5, 8'h01, 8'h99}, "R4");            // event, variable
    wr_msg('{8'hE0, 8'h00}, "R4");                   // reserved code
    ev(1, 1, 0, 0, 8'h55, "R2");                     // wrong address
    ev(1, 0, 0, 0, 8'h80, "R2");
    ev(1, 0, 0, 0, 8'h01, "R2");
    ev(1, 1, 0, 0, OWN, "R2");                       // restart mid-message
    ev(1, 0, 0, 0, 8'h80, "R2");
    ev(1, 0, 0, 0, 8'h02, "R2");
    ev(1, 0, 0, 1, 0, "R2");
    ev(1, 1, 0, 0, OWN, "R3");                       // bad status in command-wait
    ev(1, 0, 1, 0, 0, "R3");
    ev(1, 0, 0, 0, 8'h80, "R3");
    ev(1, 0, 0, 1, 0, "R3");
    ev(0, 1, 0, 0, OWN, "R14");                      // spurious, ignored
    ev(0, 0, 0, 0, 8'h80, "R14");
    ev(1, 0, 0, 1, 0, "R14");

    big.push_back(8'h01); big.push_back(8'h40);
    for (int k = 0; k < 40; k++) big.push_back(k + 3);
    wr_msg(big, "R7");
    readback("R7");

    rd_msg(3, "R10");                                // nothing queued

    load('{8'h11, 8'h22});
    rd_msg(2, "R9");
    chk(ld_ready == 1, "R11", "ld_ready freed", ld_ready, 1);

    load('{8'h33, 8'h44, 8'h55});
    ev(1, 1, 0, 0, OWN, "R11");
    ev(1, 0, 0, 0, 1, "R11");
    ev(1, 1, 1, 0, OWN, "R12");
    ev(1, 0, 1, 0, 0, "R11");
    ev(1, 0, 1, 1, 0, "R11");                        // premature end
    rd_msg(3, "R11");

    ev(1, 1, 0, 0, OWN, "R8");                       // read without 0x01
    ev(1, 0, 0, 0, 8'h07, "R8");
    ev(1, 1, 1, 0, OWN, "R8");
    ev(1, 0, 1, 0, 0, "R13");
    ev(1, 0, 1, 1, 0, "R13");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule